// File: doc/BRIEF.md
# Index/Data Host Bus Port

This block is the processor-facing slave of a peripheral whose registers are reached through two I/O locations, an index port and a data port. An ISA-style host drives the upper address lines, an address-enable qualifier, a port-select line and active-low read and write strobes. All of these are sampled on the block clock. The block compares the address against a value strapped on the board to form its chip select. It keeps the register index written to the index port. Each data-port read or write becomes exactly one request/acknowledge transaction on an internal access port.

At reset the block latches a pair of width straps that set the host data path to 8, 16 or 32 bits. It also latches a strap that sets the interrupt polarity. These values then stay fixed until the next reset. The block drives a word-width indication and a double-word-width indication with configurable polarity. It also drives an interrupt output, and presents read data as a data vector with one output enable per byte lane, so the pad ring can build the tri-state bus.

Top module: `hbi_host_if`

## Requirements
- R1: The block is selected only when host_addr[5:4] (address bits 9..8) are both 1, host_addr[3] (bit 7) is 0, host_aen is 0 and host_addr[2:0] equal the strapped id. An unselected cycle drives no lane, stores no index and issues no access.
- R2: A selected write with host_cmd=0 stores host_din[7:0] as the register index. A selected read with host_cmd=0 returns that index on bits 7..0 with all upper bits 0. After reset the index is 0.
- R3: A selected write with host_cmd=1 issues one access with acc_we=1, acc_idx equal to the stored index and acc_wdata equal to host_din with the lanes outside the current width forced to 0.
- R4: A selected read with host_cmd=1 issues one access with acc_we=0. The acknowledged acc_rdata, with lanes outside the width forced to 0, is driven on host_dout while the read strobe stays low; it is valid from the third clock edge of the strobe.
- R5: The width straps {strap_wake, strap_eedo} decode as 00 to 16-bit, 01 to 32-bit, 10 to 8-bit and 11 to 16-bit. During a selected read, host_oe is 4'b0001, 4'b0011 or 4'b1111 for 8, 16 or 32 bits.
- R6: host_oe is 0 at all times except during a selected read cycle.
- R7: word_ind is active during selected data-port cycles in 16- or 32-bit mode and inactive otherwise. Active is 0 when cfg_word_inv=0 and 1 when cfg_word_inv=1.
- R8: dword_ind is active only during selected data-port cycles in 32-bit mode. Its polarity follows cfg_dword_inv in the same way as R7.
- R9: irq_out equals int_src when strap_dw_high was 0 at reset, and equals the inverse of int_src when it was 1.
- R10: Strap inputs are taken while rst is high; changes to them after reset has ended have no effect until the next reset.
- R11: While rst is high, acc_req and host_oe are 0.
- R12: acc_req, once raised, stays high until acc_ack and falls on the next edge. A strobe held low for many cycles produces a single access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 6 | Host address bits 9..4 |
| host_aen | input | 1 | Address enable qualifier, high blocks selection |
| host_cmd | input | 1 | Port select: 1 data port, 0 index port |
| host_ior_n | input | 1 | Read strobe, active low |
| host_iow_n | input | 1 | Write strobe, active low |
| host_din | input | 32 | Data from host |
| host_dout | output | 32 | Data to host |
| host_oe | output | 4 | Output enable per byte lane |
| word_ind | output | 1 | Word-width access indication |
| dword_ind | output | 1 | Double-word access indication |
| irq_out | output | 1 | Interrupt pin level |
| strap_id | input | 3 | Board address strap |
| strap_wake | input | 1 | Width strap, high bit |
| strap_eedo | input | 1 | Width strap, low bit |
| strap_dw_high | input | 1 | Double-word indication pin pulled high |
| cfg_word_inv | input | 1 | Invert word_ind polarity |
| cfg_dword_inv | input | 1 | Invert dword_ind polarity |
| int_src | input | 1 | Internal interrupt, active high |
| acc_req | output | 1 | Internal access request |
| acc_we | output | 1 | Internal access is a write |
| acc_idx | output | 8 | Register index of the access |
| acc_wdata | output | 32 | Write data of the access |
| acc_size | output | 2 | Width code: 0 8-bit, 1 16-bit, 2 32-bit |
| acc_ack | input | 1 | Internal access acknowledge |
| acc_rdata | input | 32 | Read data with acknowledge |

## Verification
The bench walks every width strap code, including the reserved 11. A decoder that mapped 11 to 8 or 32 bits would show the wrong lane enables and the wrong masking of write data. It drives near-miss addresses: a wrong id, bit 7 set, bit 8 clear and the enable raised. A loose compare would then drive the bus, overwrite the index or issue a stray access. It holds a strobe long and withholds the acknowledge, which catches a design that re-triggers on the strobe level or drops the request early. It also changes straps after reset and flips both polarity controls, which catches straps that are sampled late and indications that ignore their configuration.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int HBI_DATA_W = 32;
  localparam int HBI_LANES  = HBI_DATA_W / 8;

  typedef enum logic [1:0] {
    BW_8  = 2'd0,
    BW_16 = 2'd1,
    BW_32 = 2'd2
  } bus_width_e;

  // Strap pair to data width; the spare code falls back to 16 bits.
  function automatic bus_width_e width_from_straps(input logic hi, input logic lo);
    unique case ({hi, lo})
      2'b01:   return BW_32;
      2'b10:   return BW_8;
      default: return BW_16;
    endcase
  endfunction

  function automatic logic [HBI_LANES-1:0] lane_enables(input bus_width_e w);
    unique case (w)
      BW_8:    return {{(HBI_LANES-1){1'b0}}, 1'b1};
      BW_32:   return {HBI_LANES{1'b1}};
      default: return {{(HBI_LANES-2){1'b0}}, 2'b11};
    endcase
  endfunction

  // Pin level of an indication: active low unless inverted.
  function automatic logic pin_level(input logic active, input logic invert);
    return (~active) ^ invert;
  endfunction
endpackage

// File: rtl/hbi_strap_cfg.sv
module hbi_strap_cfg
  import hbi_pkg::*;
#(
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ID_W-1:0] strap_id,
  input  logic            strap_wake,
  input  logic            strap_eedo,
  input  logic            strap_dw_high,
  output logic [ID_W-1:0] id_q,
  output bus_width_e      width_q,
  output logic            irq_inv_q
);
  // Straps follow the pins while reset is held, then freeze.
  always_ff @(posedge clk) begin
    if (rst) begin
      id_q      <= strap_id;
      width_q   <= width_from_straps(strap_wake, strap_eedo);
      irq_inv_q <= strap_dw_high;
    end
  end

  a_r10_strap_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(width_q) && $stable(id_q) && $stable(irq_inv_q)));
endmodule

// File: rtl/hbi_decode.sv
module hbi_decode #(
  parameter int ID_W   = 3,
  parameter int ADDR_W = ID_W + 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              aen,
  input  logic [ID_W-1:0]   id_q,
  input  logic              cmd_data,
  input  logic              ior_n,
  input  logic              iow_n,
  output logic              chip_sel,
  output logic              rd_data,
  output logic              wr_data,
  output logic              rd_index,
  output logic              wr_index,
  output logic              data_cycle
);
  localparam int TOP = ADDR_W - 1;

  logic upper_ok;
  logic rd_act;
  logic wr_act;

  assign upper_ok   = addr[TOP] & addr[TOP-1] & ~addr[TOP-2];
  assign chip_sel   = upper_ok & ~aen & (addr[ID_W-1:0] == id_q);
  assign rd_act     = chip_sel & ~ior_n;
  assign wr_act     = chip_sel & ~iow_n;
  assign rd_data    = rd_act & cmd_data;
  assign wr_data    = wr_act & cmd_data;
  assign rd_index   = rd_act & ~cmd_data;
  assign wr_index   = wr_act & ~cmd_data;
  assign data_cycle = rd_data | wr_data;
endmodule

// File: rtl/hbi_access.sv
module hbi_access
  import hbi_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = HBI_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_data,
  input  logic              wr_data,
  input  logic              wr_index,
  input  logic [DATA_W-1:0] din,
  input  bus_width_e        width,
  input  logic              acc_ack,
  input  logic [DATA_W-1:0] acc_rdata,
  output logic              acc_req,
  output logic              acc_we,
  output logic [IDX_W-1:0]  acc_idx,
  output logic [DATA_W-1:0] acc_wdata,
  output logic [IDX_W-1:0]  idx_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              start_evt
);
  localparam int LANES = DATA_W / 8;

  logic [LANES-1:0]  lanes;
  logic [DATA_W-1:0] lane_mask;
  logic              strobe_now;
  logic              strobe_q;
  logic              done_evt;

  assign lanes = lane_enables(width);

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign lane_mask[8*g +: 8] = {8{lanes[g]}};
  end

  assign strobe_now = rd_data | wr_data;
  assign start_evt  = strobe_now & ~strobe_q & ~acc_req;
  assign done_evt   = acc_req & acc_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q  <= 1'b0;
      acc_req   <= 1'b0;
      acc_we    <= 1'b0;
      acc_idx   <= '0;
      acc_wdata <= '0;
      idx_q     <= '0;
      rdata_q   <= '0;
    end else begin
      strobe_q <= strobe_now;
      if (wr_index) idx_q <= din[IDX_W-1:0];
      if (start_evt) begin
        acc_req   <= 1'b1;
        acc_we    <= wr_data;
        acc_idx   <= idx_q;
        acc_wdata <= din & lane_mask;
      end else if (done_evt) begin
        acc_req <= 1'b0;
        if (!acc_we) rdata_q <= acc_rdata & lane_mask;
      end
    end
  end

  a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !acc_ack) |=> acc_req);
  a_r12_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    (acc_req && acc_ack) |=> !acc_req);
  a_r2_index_only_on_write: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_index) |-> $stable(idx_q));
  a_r3_index_carried: assert property (@(posedge clk) disable iff (rst)
    $rose(acc_req) |-> (acc_idx == $past(idx_q)));
endmodule

// File: rtl/hbi_host_if.sv
module hbi_host_if
  import hbi_pkg::*;
#(
  parameter int ID_W   = 3,
  parameter int IDX_W  = 8,
  parameter int DATA_W = HBI_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W+2:0]   host_addr,
  input  logic              host_aen,
  input  logic              host_cmd,
  input  logic              host_ior_n,
  input  logic              host_iow_n,
  input  logic [DATA_W-1:0] host_din,
  output logic [DATA_W-1:0] host_dout,
  output logic [DATA_W/8-1:0] host_oe,
  output logic              word_ind,
  output logic              dword_ind,
  output logic              irq_out,
  input  logic [ID_W-1:0]   strap_id,
  input  logic              strap_wake,
  input  logic              strap_eedo,
  input  logic              strap_dw_high,
  input  logic              cfg_word_inv,
  input  logic              cfg_dword_inv,
  input  logic              int_src,
  output logic              acc_req,
  output logic              acc_we,
  output logic [IDX_W-1:0]  acc_idx,
  output logic [DATA_W-1:0] acc_wdata,
  output logic [1:0]        acc_size,
  input  logic              acc_ack,
  input  logic [DATA_W-1:0] acc_rdata
);
  localparam int LANES = DATA_W / 8;

  logic [ID_W-1:0]   id_q;
  bus_width_e        width_q;
  logic              irq_inv_q;
  logic              chip_sel;
  logic              rd_data;
  logic              wr_data;
  logic              rd_index;
  logic              wr_index;
  logic              data_cycle;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] rdata_q;
  logic              start_evt;
  logic              word_active;
  logic              dword_active;
  logic              read_sel;

  hbi_strap_cfg #(.ID_W(ID_W)) u_straps (
    .clk(clk), .rst(rst), .strap_id(strap_id), .strap_wake(strap_wake),
    .strap_eedo(strap_eedo), .strap_dw_high(strap_dw_high),
    .id_q(id_q), .width_q(width_q), .irq_inv_q(irq_inv_q)
  );

  hbi_decode #(.ID_W(ID_W)) u_decode (
    .addr(host_addr), .aen(host_aen), .id_q(id_q), .cmd_data(host_cmd),
    .ior_n(host_ior_n), .iow_n(host_iow_n), .chip_sel(chip_sel),
    .rd_data(rd_data), .wr_data(wr_data), .rd_index(rd_index),
    .wr_index(wr_index), .data_cycle(data_cycle)
  );

  hbi_access #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_access (
    .clk(clk), .rst(rst), .rd_data(rd_data), .wr_data(wr_data),
    .wr_index(wr_index), .din(host_din), .width(width_q),
    .acc_ack(acc_ack), .acc_rdata(acc_rdata), .acc_req(acc_req),
    .acc_we(acc_we), .acc_idx(acc_idx), .acc_wdata(acc_wdata),
    .idx_q(idx_q), .rdata_q(rdata_q), .start_evt(start_evt)
  );

  assign read_sel     = rd_data | rd_index;
  assign host_oe      = (read_sel && !rst) ? lane_enables(width_q) : '0;
  assign host_dout    = rd_index ? {{(DATA_W-IDX_W){1'b0}}, idx_q} : rdata_q;
  assign word_active  = data_cycle & (width_q != BW_8);
  assign dword_active = data_cycle & (width_q == BW_32);
  assign word_ind     = pin_level(word_active, cfg_word_inv);
  assign dword_ind    = pin_level(dword_active, cfg_dword_inv);
  assign irq_out      = int_src ^ irq_inv_q;
  assign acc_size     = width_q;

  a_r1_req_needs_sel: assert property (@(posedge clk) disable iff (rst)
    $rose(acc_req) |-> $past(chip_sel && host_cmd && !host_aen));
  a_r6_oe_only_read: assert property (@(posedge clk) disable iff (rst)
    (|host_oe) |-> (!host_ior_n && chip_sel));
  a_r8_dword_idle: assert property (@(posedge clk) disable iff (rst)
    (width_q != BW_32) |-> (dword_ind == !cfg_dword_inv));
  a_r11_quiet_in_reset: assert property (@(posedge clk)
    $past(rst) |-> (!acc_req && host_oe == '0));
  a_r1_start_selected: assert property (@(posedge clk) disable iff (rst)
    start_evt |-> chip_sel);
endmodule

// File: tb/hbi_host_if_tb_top.sv
module hbi_host_if_tb_top;
  localparam logic [5:0] GOOD_A = 6'b110101;
  localparam int NVEC = 6;
  // {wake, eedo, index, write data}
  localparam logic [41:0] VEC [NVEC] = '{
    {2'b00, 8'h12, 32'hA5A5_1234},
    {2'b01, 8'h3C, 32'hDEAD_BEEF},
    {2'b10, 8'h7F, 32'hCAFE_0099},
    {2'b11, 8'hFF, 32'h1357_9BDF},
    {2'b01, 8'h00, 32'h8000_0001},
    {2'b10, 8'h80, 32'hFFFF_FFFF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] host_addr = GOOD_A;
  logic host_aen = 1'b0, host_cmd = 1'b0, host_ior_n = 1'b1, host_iow_n = 1'b1;
  logic [31:0] host_din = '0;
  logic [31:0] host_dout;
  logic [3:0] host_oe;
  logic word_ind, dword_ind, irq_out;
  logic [2:0] strap_id = 3'b101;
  logic strap_wake = 1'b0, strap_eedo = 1'b0, strap_dw_high = 1'b0;
  logic cfg_word_inv = 1'b0, cfg_dword_inv = 1'b0, int_src = 1'b0;
  logic acc_req, acc_we, acc_ack;
  logic [7:0] acc_idx;
  logic [31:0] acc_wdata, acc_rdata;
  logic [1:0] acc_size;
  logic ack_en = 1'b1;

  int total = 0;
  int bad = 0;
  int hs_count = 0;
  logic last_we;
  logic [7:0] last_idx;
  logic [31:0] last_wdata;

  always #10 clk = ~clk;

  function automatic logic [31:0] rd_model(input logic [7:0] i);
    return {i ^ 8'hC3, i, ~i, i + 8'h11};
  endfunction

  assign acc_ack   = acc_req & ack_en;
  assign acc_rdata = rd_model(acc_idx);

  always @(posedge clk) begin
    if (!rst && acc_req && acc_ack) begin
      hs_count   <= hs_count + 1;
      last_we    <= acc_we;
      last_idx   <= acc_idx;
      last_wdata <= acc_wdata;
    end
  end

  hbi_host_if dut_i (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_aen(host_aen),
    .host_cmd(host_cmd), .host_ior_n(host_ior_n), .host_iow_n(host_iow_n),
    .host_din(host_din), .host_dout(host_dout), .host_oe(host_oe),
    .word_ind(word_ind), .dword_ind(dword_ind), .irq_out(irq_out),
    .strap_id(strap_id), .strap_wake(strap_wake), .strap_eedo(strap_eedo),
    .strap_dw_high(strap_dw_high), .cfg_word_inv(cfg_word_inv),
    .cfg_dword_inv(cfg_dword_inv), .int_src(int_src), .acc_req(acc_req),
    .acc_we(acc_we), .acc_idx(acc_idx), .acc_wdata(acc_wdata),
    .acc_size(acc_size), .acc_ack(acc_ack), .acc_rdata(acc_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Bench view of the width straps as lane enables.
  function automatic logic [3:0] exp_lanes(input logic wk, input logic ed);
    if (wk && !ed) return 4'b0001;
    if (!wk && ed) return 4'b1111;
    return 4'b0011;
  endfunction

  function automatic logic [31:0] lanes_to_mask(input logic [3:0] l);
    logic [31:0] m = '0;
    for (int b = 0; b < 4; b++) if (l[b]) m[8*b +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic do_reset(input logic wk, input logic ed, input logic dw);
    @(negedge clk);
    rst = 1'b1; strap_wake = wk; strap_eedo = ed; strap_dw_high = dw;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_op(input logic is_rd, input logic cmd, input logic [5:0] a,
                        input logic aen_v, input logic [31:0] d, input int hold,
                        output logic [31:0] dout_s, output logic [3:0] oe_s,
                        output logic w_s, output logic dw_s);
    @(negedge clk);
    host_addr = a; host_aen = aen_v; host_cmd = cmd; host_din = d;
    if (is_rd) host_ior_n = 1'b0; else host_iow_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    w_s = word_ind; dw_s = dword_ind;
    repeat (hold) @(posedge clk);
    @(negedge clk);
    dout_s = host_dout; oe_s = host_oe;
    host_ior_n = 1'b1; host_iow_n = 1'b1; host_aen = 1'b0; host_addr = GOOD_A;
    @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] dv;
    logic [3:0] oe;
    logic ws, dws;
    int n0;

    // R11: quiet while reset is held
    repeat (2) @(posedge clk);
    @(negedge clk);
    host_ior_n = 1'b0; host_cmd = 1'b1;
    @(negedge clk);
    chk("R11 req in reset", {31'd0, acc_req}, 32'd0);
    chk("R11 oe in reset", {28'd0, host_oe}, 32'd0);
    host_ior_n = 1'b1;
    do_reset(1'b0, 1'b1, 1'b0);
    bus_op(1, 0, GOOD_A, 0, 0, 2, dv, oe, ws, dws);
    chk("R2 index after reset", dv, 32'd0);

    // Table walk over width straps
    for (int v = 0; v < NVEC; v++) begin
      logic wk, ed;
      logic [7:0] ix;
      logic [31:0] wd, mk;
      logic [3:0] ln;
      {wk, ed, ix, wd} = VEC[v];
      ln = exp_lanes(wk, ed);
      mk = lanes_to_mask(ln);
      do_reset(wk, ed, 1'b0);
      bus_op(0, 0, GOOD_A, 0, {24'hFFFFFF, ix}, 1, dv, oe, ws, dws);
      chk("R7 index cycle word_ind idle", {31'd0, ws}, 32'd1);
      bus_op(1, 0, GOOD_A, 0, 0, 2, dv, oe, ws, dws);
      chk("R2 index readback", dv, {24'd0, ix});
      chk("R5 index read lanes", {28'd0, oe}, {28'd0, ln});
      n0 = hs_count;
      bus_op(0, 1, GOOD_A, 0, wd, 2, dv, oe, ws, dws);
      chk("R6 no oe on write", {28'd0, oe}, 32'd0);
      chk("R7 word_ind on write", {31'd0, ws}, {31'd0, ln == 4'b0001});
      chk("R8 dword_ind on write", {31'd0, dws}, {31'd0, ln != 4'b1111});
      chk("R12 one write access", hs_count - n0, 32'd1);
      chk("R3 write flag", {31'd0, last_we}, 32'd1);
      chk("R3 write index", {24'd0, last_idx}, {24'd0, ix});
      chk("R3 write data lanes", last_wdata, wd & mk);
      n0 = hs_count;
      bus_op(1, 1, GOOD_A, 0, 0, 2, dv, oe, ws, dws);
      chk("R4 read data", dv, rd_model(ix) & mk);
      chk("R5 read lanes", {28'd0, oe}, {28'd0, ln});
      chk("R4 read flag", {31'd0, last_we}, 32'd0);
      chk("R12 one read access", hs_count - n0, 32'd1);
    end

    // R1: near-miss addresses in 32-bit mode
    do_reset(1'b0, 1'b1, 1'b0);
    bus_op(0, 0, GOOD_A, 0, 32'h0000_0042, 1, dv, oe, ws, dws);
    n0 = hs_count;
    bus_op(1, 0, 6'b110100, 0, 0, 2, dv, oe, ws, dws);
    chk("R1 wrong id no oe", {28'd0, oe}, 32'd0);
    bus_op(1, 0, 6'b111101, 0, 0, 2, dv, oe, ws, dws);
    chk("R1 bit7 high no oe", {28'd0, oe}, 32'd0);
    bus_op(1, 0, 6'b100101, 0, 0, 2, dv, oe, ws, dws);
    chk("R1 bit8 low no oe", {28'd0, oe}, 32'd0);
    bus_op(1, 0, GOOD_A, 1, 0, 2, dv, oe, ws, dws);
    chk("R1 aen high no oe", {28'd0, oe}, 32'd0);
    bus_op(0, 0, 6'b110100, 0, 32'h0000_0099, 1, dv, oe, ws, dws);
    bus_op(0, 1, GOOD_A, 1, 32'h1111_1111, 2, dv, oe, ws, dws);
    chk("R1 unselected data write dword_ind idle", {31'd0, dws}, 32'd1);
    chk("R1 no stray access", hs_count - n0, 32'd0);
    bus_op(1, 0, GOOD_A, 0, 0, 2, dv, oe, ws, dws);
    chk("R1 index untouched", dv, 32'h0000_0042);

    // R7 / R8: inverted polarity
    cfg_word_inv = 1'b1; cfg_dword_inv = 1'b1;
    @(negedge clk);
    chk("R7 inverted idle", {31'd0, word_ind}, 32'd0);
    chk("R8 inverted idle", {31'd0, dword_ind}, 32'd0);
    bus_op(0, 1, GOOD_A, 0, 32'h0, 1, dv, oe, ws, dws);
    chk("R7 inverted active", {31'd0, ws}, 32'd1);
    chk("R8 inverted active", {31'd0, dws}, 32'd1);
    cfg_word_inv = 1'b0; cfg_dword_inv = 1'b0;

    // R12: long strobe and withheld acknowledge
    n0 = hs_count;
    bus_op(1, 1, GOOD_A, 0, 0, 8, dv, oe, ws, dws);
    chk("R12 long strobe single access", hs_count - n0, 32'd1);
    ack_en = 1'b0;
    n0 = hs_count;
    bus_op(0, 1, GOOD_A, 0, 32'h5, 3, dv, oe, ws, dws);
    @(negedge clk);
    chk("R12 req held without ack", {31'd0, acc_req}, 32'd1);
    ack_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R12 req drops after ack", {31'd0, acc_req}, 32'd0);
    chk("R12 single handshake", hs_count - n0, 32'd1);

    // R10: straps frozen after reset
    do_reset(1'b1, 1'b0, 1'b0);
    strap_wake = 1'b0; strap_eedo = 1'b1; strap_id = 3'b010;
    bus_op(1, 0, GOOD_A, 0, 0, 2, dv, oe, ws, dws);
    chk("R10 width held at 8-bit", {28'd0, oe}, 32'd1);
    strap_id = 3'b101;

    // R9: interrupt polarity strap
    int_src = 1'b1;
    @(negedge clk);
    chk("R9 irq follows source", {31'd0, irq_out}, 32'd1);
    int_src = 1'b0;
    @(negedge clk);
    chk("R9 irq idle", {31'd0, irq_out}, 32'd0);
    do_reset(1'b0, 1'b0, 1'b1);
    int_src = 1'b1;
    @(negedge clk);
    chk("R9 irq inverted active", {31'd0, irq_out}, 32'd0);
    int_src = 1'b0;
    @(negedge clk);
    chk("R9 irq inverted idle", {31'd0, irq_out}, 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule